// File: doc/BRIEF.md
# Fault Latch and Restart Sequencer

This block decides whether a resonant power stage may run. It watches a fast fault comparator flag and an undervoltage-lockout flag. On a fault it cuts the current drive pulse at once and drops the run enable. It also collapses a soft-start code to zero; that code bounds how far the frequency command may climb above its floor.

A two-bit mode input picks what happens after a fault:
- Latch-off: the block stays off until lockout or a change of mode.
- Immediate: the block resumes as soon as the fault clears.
- Hiccup: the block waits a programmed number of cycles after the fault clears, then restarts.

Analog capacitor ramps are modelled as counters. Once running, the soft-start code climbs by a programmable step on each oscillator cycle-start strobe, so the ceiling rises from the floor up to the full span.

Top module: `fault_restart_ctrl`

## Requirements
- R1: While `uvlo_i` is high, `run_o`, `kill_o` and `ss_code_o` are all 0 after the next clock edge, and any latched-off state is cleared. When `uvlo_i` falls with no fault present, `run_o` rises at the first following edge.
- R2: When `fault_i` is sampled high while running, `kill_o` is high for exactly one cycle, starting at that same edge. At that edge `run_o` and `ss_code_o` become 0.
- R3: With mode 2'b00 (latch-off), after a fault `run_o` stays 0 whatever `fault_i` does, until lockout or a mode change.
- R4: A latched-off block whose mode changes to 2'b01 while `fault_i` is low raises `run_o` at the second edge after the change.
- R5: With mode 2'b01 (immediate), `run_o` rises at the first edge that samples `fault_i` low.
- R6: With mode 2'b10, and for a hold count L, `run_o` rises at the edge L+1 edges after the first edge that samples `fault_i` low.
- R7: A fault seen during a hiccup hold-off gives no `kill_o` pulse and restarts the hold-off from zero once the fault clears.
- R8: While running, each edge with `cyc_start_i` high adds `ss_step_i` to `ss_code_o`, saturating at 2^SS_W-1. Edges without the strobe leave it unchanged.
- R9: `ss_code_o` is 0 in every cycle where `run_o` is 0, so each restart ramps from the floor.
- R10: Lockout has priority over a fault: if both are high at the same edge, no `kill_o` pulse is produced.
- R11: A fault and a cycle-start strobe at the same edge give `ss_code_o` = 0 and a `kill_o` pulse.
- R12: Mode 2'b11 behaves as hiccup mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fault_i | input | 1 | Fault comparator flag |
| uvlo_i | input | 1 | Undervoltage lockout flag |
| mode_i | input | 2 | Restart disposition: 00 latch-off, 01 immediate, 1x hiccup |
| hold_cnt_i | input | DLY_W | Hiccup hold-off count |
| ss_step_i | input | SS_W | Soft-start increment per strobe |
| cyc_start_i | input | 1 | Oscillator cycle-start strobe |
| kill_o | output | 1 | One-cycle pulse that ends the current drive pulse |
| run_o | output | 1 | Run enable |
| ss_code_o | output | SS_W | Soft-start ceiling above the frequency floor |

## Verification
Two pairs of events can fall in the same cycle.

The first pair is a fault and a cycle-start strobe. The bench drives both high at one edge while the soft-start code is nonzero. It expects the kill pulse and a zero code, so the fault must override the ramp.

The second pair is a fault and lockout. The bench drives both high at one edge and expects no kill pulse, only the lockout clear.

The hiccup hold-off is swept over every count in both hiccup encodings. The restart edge is counted exactly.

// File: rtl/fr_pkg.sv
package fr_pkg;
  typedef enum logic [2:0] {
    ST_OFF   = 3'd0,
    ST_RUN   = 3'd1,
    ST_WAIT  = 3'd2,
    ST_HOLD  = 3'd3,
    ST_LATCH = 3'd4
  } fr_state_t;

  localparam logic [1:0] MODE_LATCH = 2'b00;
  localparam logic [1:0] MODE_IMM   = 2'b01;
endpackage

// File: rtl/fr_hold_timer.sv
module fr_hold_timer #(
  parameter int DLY_W = 16
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             en,
  input  logic [DLY_W-1:0] limit,
  output logic             done
);
  logic [DLY_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (clr)     cnt <= '0;
    else if (en) cnt <= cnt + 1'b1;
  end

  assign done = (cnt == limit);
endmodule

// File: rtl/fr_softstart.sv
module fr_softstart #(
  parameter int SS_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run_nxt,
  input  logic            strobe,
  input  logic [SS_W-1:0] step,
  output logic [SS_W-1:0] code
);
  localparam logic [SS_W-1:0] FULL = {SS_W{1'b1}};
  logic [SS_W:0] sum;

  assign sum = {1'b0, code} + {1'b0, step};

  always_ff @(posedge clk) begin
    if (rst || !run_nxt) code <= '0;
    else if (strobe)     code <= sum[SS_W] ? FULL : sum[SS_W-1:0];
  end
endmodule

// File: rtl/fr_seq.sv
module fr_seq
  import fr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       fault_i,
  input  logic       uvlo_i,
  input  logic [1:0] mode_i,
  input  logic       hold_done,
  output logic       hold_en,
  output logic       hold_clr,
  output logic       run_nxt,
  output logic       run_o,
  output logic       kill_o
);
  fr_state_t st, nxt;
  logic      enter_fault;

  always_comb begin
    nxt         = st;
    enter_fault = 1'b0;
    if (uvlo_i) begin
      nxt = ST_OFF;
    end else begin
      unique case (st)
        ST_OFF: nxt = ST_RUN;
        ST_RUN: if (fault_i) begin
          enter_fault = 1'b1;
          nxt = (mode_i == MODE_LATCH) ? ST_LATCH : ST_WAIT;
        end
        ST_WAIT: if (!fault_i) begin
          if (mode_i == MODE_LATCH)    nxt = ST_LATCH;
          else if (mode_i == MODE_IMM) nxt = ST_RUN;
          else                         nxt = ST_HOLD;
        end
        ST_HOLD: begin
          if (fault_i)        nxt = ST_WAIT;
          else if (hold_done) nxt = ST_RUN;
        end
        ST_LATCH: if (mode_i != MODE_LATCH) nxt = ST_WAIT;
        default: nxt = ST_OFF;
      endcase
    end
  end

  assign run_nxt  = (nxt == ST_RUN);
  assign hold_clr = (st != ST_HOLD);
  assign hold_en  = (st == ST_HOLD) && !fault_i && !uvlo_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_OFF;
      run_o  <= 1'b0;
      kill_o <= 1'b0;
    end else begin
      st     <= nxt;
      run_o  <= run_nxt;
      kill_o <= enter_fault;
    end
  end
endmodule

// File: rtl/fault_restart_ctrl.sv
module fault_restart_ctrl #(
  parameter int DLY_W = 16,
  parameter int SS_W  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fault_i,
  input  logic             uvlo_i,
  input  logic [1:0]       mode_i,
  input  logic [DLY_W-1:0] hold_cnt_i,
  input  logic [SS_W-1:0]  ss_step_i,
  input  logic             cyc_start_i,
  output logic             kill_o,
  output logic             run_o,
  output logic [SS_W-1:0]  ss_code_o
);
  logic hold_done, hold_en, hold_clr, run_nxt;

  fr_seq u_seq (
    .clk       (clk),
    .rst       (rst),
    .fault_i   (fault_i),
    .uvlo_i    (uvlo_i),
    .mode_i    (mode_i),
    .hold_done (hold_done),
    .hold_en   (hold_en),
    .hold_clr  (hold_clr),
    .run_nxt   (run_nxt),
    .run_o     (run_o),
    .kill_o    (kill_o)
  );

  fr_hold_timer #(.DLY_W(DLY_W)) u_timer (
    .clk   (clk),
    .clr   (hold_clr | rst),
    .en    (hold_en),
    .limit (hold_cnt_i),
    .done  (hold_done)
  );

  fr_softstart #(.SS_W(SS_W)) u_ss (
    .clk     (clk),
    .rst     (rst),
    .run_nxt (run_nxt),
    .strobe  (cyc_start_i),
    .step    (ss_step_i),
    .code    (ss_code_o)
  );
endmodule

// File: rtl/fr_checker.sv
module fr_checker #(
  parameter int SS_W = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            fault_i,
  input logic            uvlo_i,
  input logic            kill_o,
  input logic            run_o,
  input logic [SS_W-1:0] ss_code_o
);
  p_uvlo_off_r1: assert property (@(posedge clk) disable iff (rst)
    uvlo_i |=> (!run_o && !kill_o && ss_code_o == '0));

  p_kill_single_r2: assert property (@(posedge clk) disable iff (rst)
    kill_o |=> !kill_o);

  p_kill_stops_run_r2: assert property (@(posedge clk) disable iff (rst)
    kill_o |-> !run_o);

  p_kill_cause_r10: assert property (@(posedge clk) disable iff (rst)
    kill_o |-> ($past(fault_i) && $past(run_o) && !$past(uvlo_i)));

  p_ss_zero_off_r9: assert property (@(posedge clk) disable iff (rst)
    !run_o |-> ss_code_o == '0);

  p_ss_rising_r8: assert property (@(posedge clk) disable iff (rst)
    (run_o && $past(run_o)) |-> ss_code_o >= $past(ss_code_o));
endmodule

bind fault_restart_ctrl fr_checker #(.SS_W(SS_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .fault_i   (fault_i),
  .uvlo_i    (uvlo_i),
  .kill_o    (kill_o),
  .run_o     (run_o),
  .ss_code_o (ss_code_o)
);

// File: tb/fault_restart_ctrl_tb.sv
module fault_restart_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DLY_W = 4;
  localparam int SS_W  = 4;
  localparam int FULL  = (1 << SS_W) - 1;

  logic clk = 1'b0;
  logic rst, fault_i, uvlo_i, cyc_start_i;
  logic [1:0] mode_i;
  logic [DLY_W-1:0] hold_cnt_i;
  logic [SS_W-1:0] ss_step_i;
  logic kill_o, run_o;
  logic [SS_W-1:0] ss_code_o;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fault_restart_ctrl #(.DLY_W(DLY_W), .SS_W(SS_W)) u_dut (
    .clk(clk), .rst(rst), .fault_i(fault_i), .uvlo_i(uvlo_i), .mode_i(mode_i),
    .hold_cnt_i(hold_cnt_i), .ss_step_i(ss_step_i), .cyc_start_i(cyc_start_i),
    .kill_o(kill_o), .run_o(run_o), .ss_code_o(ss_code_o));

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic count_restart(input string req, input int exp);
    int n = 0;
    while (!run_o && n < 40) begin
      step();
      n++;
    end
    chk(n == exp, req, n, exp);
  endtask

  task automatic trip();
    fault_i = 1'b1;
    step();
    chk(kill_o == 1'b1 && run_o == 1'b0 && ss_code_o == 0, "R2 entry", kill_o, 1);
    step();
    chk(kill_o == 1'b0, "R2 single pulse", kill_o, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1; fault_i = 0; uvlo_i = 0; cyc_start_i = 0;
    mode_i = 2'b01; hold_cnt_i = '0; ss_step_i = '0;
    repeat (3) step();
    chk(!run_o && !kill_o && ss_code_o == 0, "R1 reset state", run_o, 0);
    rst = 0;
    step();
    chk(run_o == 1'b1, "R1 start after release", run_o, 1);

    // R10: lockout and fault at the same edge
    uvlo_i = 1; fault_i = 1;
    step();
    chk(kill_o == 1'b0 && run_o == 1'b0, "R10 no kill under lockout", kill_o, 0);
    uvlo_i = 0; fault_i = 0;
    step();
    chk(run_o == 1'b1, "R1 restart after lockout", run_o, 1);

    // R3: latch-off holds, cleared by lockout
    mode_i = 2'b00;
    trip();
    fault_i = 0;
    repeat (3) step();
    fault_i = 1; step(); fault_i = 0;
    repeat (4) step();
    chk(run_o == 1'b0 && kill_o == 1'b0, "R3 latched off", run_o, 0);
    uvlo_i = 1; step();
    chk(run_o == 1'b0 && ss_code_o == 0, "R1 off in lockout", run_o, 0);
    uvlo_i = 0; step();
    chk(run_o == 1'b1, "R1 latch cleared", run_o, 1);

    // R4: latch cleared by mode change
    trip();
    fault_i = 0;
    repeat (3) step();
    mode_i = 2'b01;
    count_restart("R4 mode change restart", 2);

    // R11: fault and strobe together with a nonzero ramp
    ss_step_i = 4'd3;
    cyc_start_i = 1; step(); step(); cyc_start_i = 0;
    chk(ss_code_o == 6, "R8 ramp before collision", ss_code_o, 6);
    fault_i = 1; cyc_start_i = 1;
    step();
    cyc_start_i = 0;
    chk(kill_o == 1'b1 && ss_code_o == 0, "R11 fault beats strobe", ss_code_o, 0);
    fault_i = 0;
    count_restart("R5 immediate resume", 1);

    // R7: fault during hold-off
    mode_i = 2'b10; hold_cnt_i = 4'd5;
    trip();
    fault_i = 0; step(); step();
    fault_i = 1; step();
    chk(kill_o == 1'b0 && run_o == 1'b0, "R7 no kill in hold-off", kill_o, 0);
    fault_i = 0;
    count_restart("R7 hold-off restarted", 7);

    // R6/R12: hold-off sweep over every count, both hiccup codes
    for (int m = 2; m < 4; m++) begin
      for (int l = 0; l < (1 << DLY_W); l++) begin
        mode_i = m[1:0]; hold_cnt_i = l[DLY_W-1:0];
        fault_i = 1; step(); step();
        fault_i = 0;
        count_restart(m == 2 ? "R6 hiccup delay" : "R12 mode 11 hiccup", l + 2);
      end
    end

    // R8/R9: ramp sweep over every step value
    mode_i = 2'b01;
    for (int s = 0; s <= FULL; s++) begin
      fault_i = 1; step();
      chk(ss_code_o == 0 && run_o == 0, "R9 zero while off", ss_code_o, 0);
      fault_i = 0; step();
      ss_step_i = s[SS_W-1:0];
      for (int k = 1; k <= FULL + 2; k++) begin
        int e;
        e = (k * s > FULL) ? FULL : k * s;
        cyc_start_i = 1; step(); cyc_start_i = 0;
        chk(ss_code_o == e, "R8 ramp value", ss_code_o, e);
        step();
        chk(ss_code_o == e, "R8 hold without strobe", ss_code_o, e);
      end
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule